// File: doc/BRIEF.md
# Interrupt-Capable 32-Pin I/O Bank

This block is one bank of 32 general-purpose pins. Software reaches it through a small memory-mapped register port. The bank holds:

- an output value and a drive enable for each pin;
- a routing bit and an enable bit for each pin's interrupt;
- two bits for each pin that choose edge or level detection and the active sense.

Pin inputs pass through a two-flop synchroniser. The synchronised value is readable at all times, whether or not the pin is driven. When a pin's routing bit is set, a matching edge or level latches a sticky status bit. Only a write of ones to the clear alias of the status register removes that bit.

The bank has two interrupt lines. With `SPLIT_IRQ=1` (the default), `irq_a` serves pins 0..15 and `irq_b` serves pins 16..31. With `SPLIT_IRQ=0`, `irq_a` covers all 32 pins and `irq_b` stays low.

The register port is a request/response stream:
- A request moves on a cycle where `req_valid` and `req_ready` are both high.
- A read produces one response, held in a single-entry buffer.
- While that buffer is full and `rsp_ready` is low, `req_ready` is low. The response word then stays unchanged until it is taken.
- Writes produce no response.

Top module: `pin_bank_irq`

## Requirements
- R1: After reset every register reads zero, and `pin_out`, `pin_oe`, `irq_a` and `irq_b` are zero.
- R2: Address bits [6:4] select the register: 0 polarity, 1 level-select, 2 interrupt enable, 3 routing, 4 drive enable, 5 output value, 6 input, 7 status. Bits [3:2] select the alias: 0 writes the value, 1 ORs in the written ones, 2 clears the written ones, 3 ignores the write. Reads return the register from any alias.
- R3: `pin_out` equals the output-value register and `pin_oe` equals the drive-enable register, starting the cycle after the write is accepted.
- R4: The input register returns `pin_in` delayed by two clocks, regardless of the drive enable.
- R5: Writes to the input register, and normal or set-alias writes to the status register, leave them unchanged.
- R6: A status bit stays set until a clear-alias status write with a one in that bit. A pin returning to its idle level does not clear it.
- R7: Pin modes: level-select 0 with polarity 1 is rising edge; level-select 0 with polarity 0 is falling edge; level-select 1 with polarity 1 is high level; level-select 1 with polarity 0 is low level. A status bit is set one clock after the synchronised input shows the event.
- R8: A pin whose routing bit is 0 never sets its status bit.
- R9: In level mode, a status bit cleared while its active level persists is set again at once.
- R10: An interrupt line is high exactly when some pin in its half (in split mode) has both its status bit and its enable bit set. With all enables zero, both lines are low.
- R11: While a read response waits with `rsp_ready` low, `req_ready` is low and `rsp_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 8 | Register select and alias |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |
| pin_in | input | 32 | Pin levels from pads |
| pin_out | output | 32 | Output value to pads |
| pin_oe | output | 32 | Drive enable to pads |
| irq_a | output | 1 | Interrupt for pins 0..15, or all pins |
| irq_b | output | 1 | Interrupt for pins 16..31, or tied low |

## Verification
A wrong mode decode or a missing routing gate appears three clocks after a pin change. It shows as a status word that differs on readback and as an interrupt line at the wrong level. A clear that fails to take effect, or a status bit that drops by itself, shows on the next status read. A faulty alias decode corrupts `pin_out` or `pin_oe` one clock after the write. A response buffer that loses data under back-pressure shows at once as a changed `rsp_data` or an unexpected `req_ready`.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  typedef enum logic [2:0] {
    SEL_POL   = 3'd0,
    SEL_LEV   = 3'd1,
    SEL_IEN   = 3'd2,
    SEL_ROUTE = 3'd3,
    SEL_OE    = 3'd4,
    SEL_DOUT  = 3'd5,
    SEL_DIN   = 3'd6,
    SEL_STAT  = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    AL_WRITE = 2'd0,
    AL_SET   = 2'd1,
    AL_CLR   = 2'd2,
    AL_NONE  = 2'd3
  } alias_e;

  localparam int NUM_REGS = 8;
endpackage

// File: rtl/pgb_sync.sv
module pgb_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [STAGES:0][W-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign cur  = chain_q[STAGES-1];
  assign prev = chain_q[STAGES];
endmodule

// File: rtl/pgb_detect.sv
module pgb_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] lev,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] route,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat
);
  logic [W-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      always_comb begin
        if (lev[i]) hit[i] = pol[i] ? cur[i] : ~cur[i];
        else        hit[i] = pol[i] ? (cur[i] & ~prev[i]) : (~cur[i] & prev[i]);
      end
    end
  endgenerate

  // set wins over clear so a persisting level re-arms at once
  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_mask) | (hit & route);
  end

  // R6
  sticky_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask == '0) |=> ((stat & $past(stat)) == $past(stat)));

  // R8
  route_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(route)) == '0));
endmodule

// File: rtl/pgb_regs.sv
module pgb_regs
  import pgb_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [W-1:0]      req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [W-1:0]      rsp_data,
  input  logic [W-1:0]      din,
  input  logic [W-1:0]      stat,
  output logic [W-1:0]      dout,
  output logic [W-1:0]      oe,
  output logic [W-1:0]      route,
  output logic [W-1:0]      ien,
  output logic [W-1:0]      lev,
  output logic [W-1:0]      pol,
  output logic [W-1:0]      stat_clr
);
  localparam int SEL_LSB = 4;
  localparam int AL_LSB  = 2;

  reg_sel_e     sel;
  alias_e       al;
  logic         accept;
  logic [W-1:0] regs_q [NUM_REGS];
  logic [W-1:0] rd_word;

  assign sel       = reg_sel_e'(req_addr[SEL_LSB+2:SEL_LSB]);
  assign al        = alias_e'(req_addr[AL_LSB+1:AL_LSB]);
  assign req_ready = ~rsp_valid | rsp_ready;
  assign accept    = req_valid & req_ready;

  genvar k;
  generate
    for (k = 0; k < NUM_REGS; k++) begin : g_reg
      if (k == int'(SEL_DIN) || k == int'(SEL_STAT)) begin : g_ro
        assign regs_q[k] = '0;
      end else begin : g_rw
        always_ff @(posedge clk) begin
          if (!rst_n) regs_q[k] <= '0;
          else if (accept && req_write && int'(sel) == k) begin
            case (al)
              AL_WRITE: regs_q[k] <= req_wdata;
              AL_SET:   regs_q[k] <= regs_q[k] | req_wdata;
              AL_CLR:   regs_q[k] <= regs_q[k] & ~req_wdata;
              default:  regs_q[k] <= regs_q[k];
            endcase
          end
        end
      end
    end
  endgenerate

  assign pol   = regs_q[SEL_POL];
  assign lev   = regs_q[SEL_LEV];
  assign ien   = regs_q[SEL_IEN];
  assign route = regs_q[SEL_ROUTE];
  assign oe    = regs_q[SEL_OE];
  assign dout  = regs_q[SEL_DOUT];

  assign stat_clr = (accept && req_write && sel == SEL_STAT && al == AL_CLR)
                    ? req_wdata : '0;

  always_comb begin
    case (sel)
      SEL_DIN:  rd_word = din;
      SEL_STAT: rd_word = stat;
      default:  rd_word = regs_q[sel];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  logic unused_addr;
  assign unused_addr = ^{req_addr[AL_LSB-1:0], req_addr[ADDR_W-1:SEL_LSB+3]};

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R2
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && sel == SEL_DOUT && al == AL_SET)
      |=> ((dout & $past(req_wdata)) == $past(req_wdata)));
endmodule

// File: rtl/pin_bank_irq.sv
module pin_bank_irq #(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit SPLIT_IRQ   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PINS-1:0]   req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PINS-1:0]   rsp_data,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq_a,
  output logic              irq_b
);
  localparam int HALF = PINS / 2;

  logic [PINS-1:0] cur, prev, stat, route, ien, lev, pol, clr_mask, pend;

  pgb_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur), .prev(prev));

  pgb_regs #(.W(PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .din(cur), .stat(stat),
    .dout(pin_out), .oe(pin_oe), .route(route), .ien(ien),
    .lev(lev), .pol(pol), .stat_clr(clr_mask));

  pgb_detect #(.W(PINS)) u_det (
    .clk(clk), .rst_n(rst_n), .cur(cur), .prev(prev), .lev(lev), .pol(pol),
    .route(route), .clr_mask(clr_mask), .stat(stat));

  assign pend = stat & ien;

  generate
    if (SPLIT_IRQ) begin : g_split
      assign irq_a = |pend[HALF-1:0];
      assign irq_b = |pend[PINS-1:HALF];
    end else begin : g_single
      assign irq_a = |pend;
      assign irq_b = 1'b0;
    end
  endgenerate

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> (!irq_a && !irq_b));
endmodule

// File: tb/pin_bank_irq_bench.sv
module pin_bank_irq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0, pin_in = '0;
  logic        req_ready, rsp_valid, irq_a, irq_b;
  logic [31:0] rsp_data, pin_out, pin_oe;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_bank_irq u_pin_bank_irq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_a(irq_a), .irq_b(irq_b));

  // register indices and aliases, per R2
  localparam logic [2:0] POL = 0, LEV = 1, IEN = 2, ROUTE = 3, OE = 4,
                         DOUT = 5, DIN = 6, STAT = 7;
  localparam logic [1:0] WR = 0, SET = 1, CLR = 2;

  function automatic logic [7:0] addr(input logic [2:0] s, input logic [1:0] a);
    return {1'b0, s, a, 2'b00};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: %0d responses missing, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic issue(input logic wr, input logic [7:0] a, input logic [31:0] d);
    logic rdy;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      #1 rdy = req_ready;
      @(posedge clk);
    end while (!rdy);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] a, input logic [31:0] d);
    issue(1'b1, addr(s, a), d);
  endtask

  task automatic rd(input string tag, input logic [2:0] s, input logic [31:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    issue(1'b0, addr(s, WR), '0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each response as it is handed over
  always begin
    @(negedge clk);
    #1;
    if (rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected response %h, expected none", rsp_data);
      end else begin
        check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_oe", pin_oe, '0);
    check("R1 irq", {30'd0, irq_b, irq_a}, '0);
    for (int s = 0; s < 8; s++) rd("R1 reg reset", s[2:0], '0);

    // R2 aliases, R3 output pins
    wr(DOUT, WR, 32'hA5A5_0000);
    wr(DOUT, SET, 32'h0000_00FF);
    rd("R2 set alias", DOUT, 32'hA5A5_00FF);
    wr(DOUT, CLR, 32'hA500_000F);
    rd("R2 clear alias", DOUT, 32'h00A5_00F0);
    check("R3 pin_out", pin_out, 32'h00A5_00F0);
    issue(1'b1, {1'b0, DOUT, 2'd3, 2'b00}, 32'hFFFF_FFFF);
    rd("R2 ignored alias", DOUT, 32'h00A5_00F0);
    wr(OE, WR, 32'h0000_FF00);
    check("R3 pin_oe", pin_oe, 32'h0000_FF00);

    // R4 input follows pins regardless of drive
    @(negedge clk) pin_in = 32'h1200_0300;
    idle(3);
    rd("R4 din", DIN, 32'h1200_0300);
    wr(DIN, WR, 32'hFFFF_FFFF);
    rd("R5 din write ignored", DIN, 32'h1200_0300);
    @(negedge clk) pin_in = '0;
    idle(3);

    // R7 rising edge on pin 3, R6 sticky, R10 split lines
    wr(ROUTE, SET, 32'h8);
    wr(IEN, SET, 32'h8);
    wr(POL, SET, 32'h8);
    idle(3);
    rd("R7 no event yet", STAT, '0);
    @(negedge clk) pin_in[3] = 1'b1;
    idle(4);
    rd("R7 rising", STAT, 32'h8);
    check("R10 irq_a", {31'd0, irq_a}, 1);
    check("R10 irq_b", {31'd0, irq_b}, 0);
    @(negedge clk) pin_in[3] = 1'b0;
    idle(4);
    rd("R6 sticky after release", STAT, 32'h8);
    wr(STAT, WR, 32'h0);
    wr(STAT, SET, 32'hFFFF_0000);
    rd("R5 status normal/set ignored", STAT, 32'h8);
    wr(STAT, CLR, 32'h8);
    rd("R6 cleared", STAT, '0);
    check("R10 irq_a after clear", {31'd0, irq_a}, 0);

    // R8 routing gate, R7 falling edge on pin 20
    @(negedge clk) pin_in[20] = 1'b1;
    idle(4);
    @(negedge clk) pin_in[20] = 1'b0;
    idle(4);
    rd("R8 unrouted edge", STAT, '0);
    @(negedge clk) pin_in[20] = 1'b1;
    idle(4);
    wr(ROUTE, SET, 32'h0010_0000);
    wr(IEN, SET, 32'h0010_0000);
    idle(2);
    rd("R7 no fall yet", STAT, '0);
    @(negedge clk) pin_in[20] = 1'b0;
    idle(4);
    rd("R7 falling", STAT, 32'h0010_0000);
    check("R10 irq_b upper", {31'd0, irq_b}, 1);
    check("R10 irq_a upper", {31'd0, irq_a}, 0);
    wr(STAT, CLR, 32'h0010_0000);
    check("R10 irq_b cleared", {31'd0, irq_b}, 0);

    // R9 high level on pin 5 re-arms
    wr(LEV, SET, 32'h20);
    wr(POL, SET, 32'h20);
    wr(ROUTE, SET, 32'h20);
    @(negedge clk) pin_in[5] = 1'b1;
    idle(4);
    wr(STAT, CLR, 32'h20);
    rd("R9 level re-arms", STAT, 32'h20);
    @(negedge clk) pin_in[5] = 1'b0;
    idle(4);
    wr(STAT, CLR, 32'h20);
    rd("R9 level gone", STAT, '0);

    // R7 low level on pin 7, R10 enable gating
    wr(LEV, SET, 32'h80);
    wr(ROUTE, SET, 32'h80);
    idle(2);
    rd("R7 low level", STAT, 32'h80);
    check("R10 masked", {31'd0, irq_a}, 0);
    wr(IEN, SET, 32'h80);
    check("R10 enabled", {31'd0, irq_a}, 1);
    wr(ROUTE, CLR, 32'h80);
    wr(STAT, CLR, 32'h80);
    rd("R8 unrouted level", STAT, '0);
    check("R10 gone", {31'd0, irq_a}, 0);

    // R11 back-pressure
    @(negedge clk) rsp_ready = 1'b0;
    exp_q.push_back(32'h00A5_00F0);
    tag_q.push_back("R11 released data");
    issue(1'b0, addr(DOUT, WR), '0);
    for (int c = 0; c < 3; c++) begin
      #1;
      check("R11 req_ready low", {31'd0, req_ready}, 0);
      check("R11 data held", rsp_data, 32'h00A5_00F0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    idle(3);
    summary();
  end
endmodule